// File: doc/BRIEF.md
# Two-Level Lookahead 16-Bit Adder

This block adds two 16-bit operands and a carry-in. It returns a 16-bit sum and a carry-out. The operands are cut into four slices of four bits each. Each slice forms a propagate and a generate for every bit. It derives all of its internal carries directly from the carry that enters the slice, so no carry ripples through the slice. Each slice also reports one propagate and one generate for the slice as a whole.

A second lookahead unit takes those slice signals and the carry-in. It produces the carries that enter slices one to three and the final carry-out, using the same sum-of-products form as the slices. No carry ripples from slice to slice either.

The block is purely combinational. It has no clock, no reset and no handshake. It is meant to sit inside a datapath stage whose registers belong to the surrounding logic. The slice width and the slice count are parameters, and the defaults give 16 bits.

Top module: `cla16_adder`

## Requirements
- R1: For every input combination, the 17-bit value {c_out, sum_out} equals a_in + b_in + c_in, computed as an unsigned 17-bit sum.
- R2: Each bit has a propagate (a XOR b) and a generate (a AND b), and its sum bit is the propagate XOR the carry entering that bit. When b_in is the bitwise inverse of a_in, every bit propagates. In that case sum_out is 16'hFFFF and c_out is 0 when c_in is 0, and sum_out is 16'h0000 and c_out is 1 when c_in is 1.
- R3: The carry entering each bit i equals bit i of (a_in[i-1:0] + b_in[i-1:0] + c_in), where bit 0's carry is c_in. This carry is observable at the ports as sum_out[i] XOR a_in[i] XOR b_in[i]. Inside a slice, each carry also satisfies carry[i+1] = g[i] OR (p[i] AND carry[i]).
- R4: The carry entering slice k, at bit position 4k, equals bit 4k of the low 4k bits of a_in plus b_in plus c_in. c_out equals the overall generate OR (the overall propagate AND c_in), formed from the four slice propagate/generate pairs.
- R5: The block is combinational. Outputs follow the inputs without any clock edge, and all-zero inputs give sum_out = 0 and c_out = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| c_out | output | 1 | Carry out of bit 15 |

## Verification
Every result of this block is due in the same cycle as its stimulus, with zero register stages. The sum, each bit carry and the carry-out settle after gate delay only.

The bench changes operands on the falling clock edge and compares one nanosecond later, well before the next rising edge. This proves that no edge is needed to produce a result. Per-bit and per-slice carries are recovered at the ports from sum_out XOR a_in XOR b_in and compared with carries computed arithmetically from partial sums.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned DEF_SLICE_W  = 4;
  localparam int unsigned DEF_SLICE_N  = 4;
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int unsigned W = cla_pkg::DEF_SLICE_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p,
  output logic [W-1:0] g
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign p[i] = a[i] ^ b[i];
      assign g[i] = a[i] & b[i];
    end
  endgenerate

  // R2: a bit cannot both propagate and generate
  always_comb begin
    p_pg_exclusive_r2: assert ((p & g) == '0)
      else $error("bit propagate and generate both high");
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned N = cla_pkg::DEF_SLICE_W
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  input  logic         cin,
  output logic [N:0]   c,
  output logic         grp_p,
  output logic         grp_g
);
  // Every carry is a flat sum of products of p, g and cin; no term
  // reuses a previously computed carry.
  always_comb begin
    logic acc;
    logic prod;
    c[0] = cin;
    for (int i = 0; i < N; i++) begin
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        prod = g[j];
        for (int k = j + 1; k <= i; k++) prod = prod & p[k];
        acc = acc | prod;
      end
      prod = cin;
      for (int k = 0; k <= i; k++) prod = prod & p[k];
      c[i+1] = acc | prod;
    end
  end

  always_comb begin
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      prod = g[j];
      for (int k = j + 1; k < N; k++) prod = prod & p[k];
      acc = acc | prod;
    end
    grp_g = acc;
    grp_p = &p;
  end

  // R3: flat expansion agrees with the step-by-step carry recurrence
  always_comb begin
    for (int i = 0; i < N; i++) begin
      p_ripple_match_r3: assert (c[i+1] == (g[i] | (p[i] & c[i])))
        else $error("lookahead carry %0d disagrees with recurrence", i+1);
    end
  end

  // R3/R4: top carry consistent with exported group pair
  always_comb begin
    p_cout_consistent_r3: assert (c[N] == (grp_g | (grp_p & cin)))
      else $error("group carry-out disagrees with group P/G");
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned W = cla_pkg::DEF_SLICE_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         gp,
  output logic         gg
);
  logic [W-1:0] bp;
  logic [W-1:0] bg;
  logic [W:0]   carry;

  cla_bit_pg #(.W(W)) u_pg (
    .a (a),
    .b (b),
    .p (bp),
    .g (bg)
  );

  cla_lookahead #(.N(W)) u_lc (
    .p     (bp),
    .g     (bg),
    .cin   (cin),
    .c     (carry),
    .grp_p (gp),
    .grp_g (gg)
  );

  assign sum = bp ^ carry[W-1:0];

  // R4: a slice by itself forms the correct partial sum
  always_comb begin
    p_group_sum_r4: assert ({carry[W], sum} ==
                            ((W+1)'(a) + (W+1)'(b) + (W+1)'(cin)))
      else $error("slice partial sum wrong");
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int unsigned SLICE_W = cla_pkg::DEF_SLICE_W,
  parameter int unsigned SLICE_N = cla_pkg::DEF_SLICE_N
) (
  input  logic [SLICE_W*SLICE_N-1:0] a_in,
  input  logic [SLICE_W*SLICE_N-1:0] b_in,
  input  logic                       c_in,
  output logic [SLICE_W*SLICE_N-1:0] sum_out,
  output logic                       c_out
);
  localparam int unsigned WIDTH = SLICE_W * SLICE_N;

  logic [SLICE_N-1:0] sl_p;
  logic [SLICE_N-1:0] sl_g;
  logic [SLICE_N:0]   sl_c;
  logic               all_p;
  logic               all_g;

  genvar k;
  generate
    for (k = 0; k < SLICE_N; k++) begin : g_slice
      cla_group #(.W(SLICE_W)) u_grp (
        .a   (a_in[k*SLICE_W +: SLICE_W]),
        .b   (b_in[k*SLICE_W +: SLICE_W]),
        .cin (sl_c[k]),
        .sum (sum_out[k*SLICE_W +: SLICE_W]),
        .gp  (sl_p[k]),
        .gg  (sl_g[k])
      );
    end
  endgenerate

  cla_lookahead #(.N(SLICE_N)) u_lcu (
    .p     (sl_p),
    .g     (sl_g),
    .cin   (c_in),
    .c     (sl_c),
    .grp_p (all_p),
    .grp_g (all_g)
  );

  assign c_out = sl_c[SLICE_N];

  // R1: whole-word result equals the arithmetic sum
  always_comb begin
    p_full_sum_r1: assert ({c_out, sum_out} ==
                           ((WIDTH+1)'(a_in) + (WIDTH+1)'(b_in) + (WIDTH+1)'(c_in)))
      else $error("adder result wrong");
  end

  // R4: carry-out agrees with the overall propagate/generate pair
  always_comb begin
    p_top_pg_r4: assert (c_out == (all_g | (all_p & c_in)))
      else $error("carry-out disagrees with overall P/G");
  end
endmodule

// File: tb/cla16_adder_tb.sv
`timescale 1ns/1ps
module cla16_adder_tb;
  localparam int SW = 4;
  localparam int SN = 4;
  localparam int W  = SW * SN;

  logic         clk = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         c_in = 1'b0;
  logic [W-1:0] sum_out;
  logic         c_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cla16_adder #(.SLICE_W(SW), .SLICE_N(SN)) u_dut (
    .a_in    (a_in),
    .b_in    (b_in),
    .c_in    (c_in),
    .sum_out (sum_out),
    .c_out   (c_out)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h c=%0b)", req, act, exp, a_in, b_in, c_in);
    end
  endtask

  // Drive at falling edge, sample 1 ns later (no clock edge between).
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    logic [W:0] full;
    logic [W:0] part;
    @(negedge clk);
    a_in = a; b_in = b; c_in = c;
    #1;
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    check("R1", {c_out, sum_out}, full);
    for (int i = 1; i < W; i++) begin
      part = ({1'b0, a} & ((17'd1 << i) - 1)) + ({1'b0, b} & ((17'd1 << i) - 1)) + {{W{1'b0}}, c};
      if (i % SW == 0)
        check("R4", {{W{1'b0}}, sum_out[i] ^ a[i] ^ b[i]}, {{W{1'b0}}, part[i]});
      else if (i < SW)
        check("R3", {{W{1'b0}}, sum_out[i] ^ a[i] ^ b[i]}, {{W{1'b0}}, part[i]});
    end
  endtask

  initial begin
    logic [31:0] lfsr;
    // R5: all-zero operands give zero without any clock edge
    #1;
    check("R5", {c_out, sum_out}, '0);
    // R5: change mid high-phase, result present before next edge
    @(posedge clk); #0.5;
    a_in = 16'h1234; b_in = 16'h0FFF; c_in = 1'b1; #1;
    check("R5", {c_out, sum_out}, 17'h1234 + 17'h0FFF + 17'd1);

    // Near-exhaustive slice sweep: replicated and mixed nibble patterns
    for (int ai = 0; ai < 16; ai++)
      for (int bi = 0; bi < 16; bi++)
        for (int ci = 0; ci < 2; ci++) begin
          apply({4{ai[3:0]}}, {4{bi[3:0]}}, ci[0]);
          apply({ai[3:0], bi[3:0], ~ai[3:0], ai[3:0]},
                {bi[3:0], ~bi[3:0], ai[3:0], ~bi[3:0]}, ci[0]);
        end

    // R2: full propagate, b = ~a
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 64; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr[15:0], ~lfsr[15:0], 1'b0);
      check("R2", {c_out, sum_out}, {1'b0, 16'hFFFF});
      apply(lfsr[15:0], ~lfsr[15:0], 1'b1);
      check("R2", {c_out, sum_out}, {1'b1, 16'h0000});
    end

    // R4: boundary carries into each slice and out of the top
    apply(16'hFFFF, 16'h0001, 1'b0);
    apply(16'hFFFF, 16'h0000, 1'b1);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'h000F, 16'h0001, 1'b0);
    apply(16'h00F0, 16'h0010, 1'b0);
    apply(16'h0F00, 16'h0100, 1'b0);
    apply(16'hF000, 16'h1000, 1'b0);
    apply(16'h8000, 16'h8000, 1'b0);

    // R1: pseudo-random operands
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr[15:0], lfsr[31:16], lfsr[7]);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule